// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

This block is a synchronous single-port memory with a one-cycle late-write protocol and a registered read output. On every rising clock edge it captures the address, the global write enable, the per-lane write mask and the synchronous select. The data for a write is taken one edge later. It is parked in a write buffer together with the write's address and mask, and it reaches the array only when the next write command has its data captured.

Reads compare their address with the parked write. On a hit, each lane that the parked write enabled is taken from the buffer, and every other lane comes from the array. A read therefore always returns the newest data, even though the array itself lags behind.

The shared data bus is modelled as a separate input, a separate output and a drive-enable. The drive-enable is high only in the output slot of a read cycle, and only while the asynchronous output enable is asserted.

Top module: `lwsram_core`

## Requirements
- R1: A read command (sel=1, wrEn=0) captured at edge T drives its word on dqOut with dqDrive=1 after edge T+1, provided outEn is high.
- R2: The data of a write command captured at edge T is taken from dqIn at edge T+1. The value on dqIn at edge T is ignored.
- R3: A parked write stays visible to reads across any number of intervening reads and deselects. When a later write's data is captured, the parked write is committed to the array and stays readable from there.
- R4: A read whose address equals the parked write's address takes each lane enabled in that write's mask from the buffer, and each other lane from the array.
- R5: The word is LANES lanes of LANE_W bits. Lane i occupies bits [i*LANE_W +: LANE_W] and is written only when laneWe[i]=1. With the defaults, lane 0 is bits 0-8 and lane 3 is bits 27-35.
- R6: A write with laneWe all zero changes no stored byte. It still replaces the parked write.
- R7: A write cycle or a deselect cycle (sel=0) captured at edge T leaves dqDrive low after edge T+1.
- R8: outEn low forces dqDrive low at once, without waiting for a clock edge.
- R9: After reset, dqDrive is low, no parked write exists, and every address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Synchronous select; 0 makes the cycle a deselect |
| wrEn | input | 1 | Global write enable; 1 makes a selected cycle a write |
| addrIn | input | ADDR_W | Word address |
| laneWe | input | LANES | Per-lane write mask captured with the write command |
| dqIn | input | DATA_W | Data bus input; write data, sampled one edge after the command |
| dqOut | output | DATA_W | Data bus output value from the output register |
| dqDrive | output | 1 | Bus drive enable; low means high impedance |
| outEn | input | 1 | Asynchronous output enable |

## Verification
The case that is hardest to reach from the ports is a read that hits the parked write with a partial mask, while the array already holds different, older bytes at that address. Reaching it takes a full write, then a partial write to the same address, then a read. The partial write must stay parked, so no other write's data may be captured in between. The directed sequences build exactly this order. The random phase confines addresses to eight words and draws random masks, zero included, so hits on partially enabled parked writes recur many times across interleaved reads and deselects.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  // strobes from control to datapath for the cycle after capture
  typedef struct packed {
    logic loadBuf;  // write data arrives: commit old buffer, park new write
    logic readLd;   // read: load merged word into output register
  } strb_t;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [LANES-1:0]  laneWe,
  output strb_t             strb,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [LANES-1:0]  cmdMask,
  output logic              driveSlot
);
  logic cmdValid;
  logic cmdWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      cmdWrite  <= 1'b0;
      cmdAddr   <= '0;
      cmdMask   <= '0;
      driveSlot <= 1'b0;
    end else begin
      cmdValid  <= sel;
      cmdWrite  <= wrEn;
      cmdAddr   <= addrIn;
      cmdMask   <= laneWe;
      driveSlot <= strb.readLd;
    end
  end

  always_comb begin
    strb.loadBuf = cmdValid & cmdWrite;
    strb.readLd  = cmdValid & ~cmdWrite;
  end
endmodule

// File: rtl/lwsram_dpath.sv
module lwsram_dpath
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LANES-1:0]  cmdMask,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] outData,
  output logic              bufValid,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [LANES*LANE_W-1:0] bufData
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  bufMask;
  logic [DATA_W-1:0] arrWord;
  logic [DATA_W-1:0] rdMerged;
  logic              bufHit;

  assign arrWord = mem[cmdAddr];
  assign bufHit  = bufValid && (bufAddr == cmdAddr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdMerged[l*LANE_W +: LANE_W] = (bufHit && bufMask[l]) ?
        bufData[l*LANE_W +: LANE_W] : arrWord[l*LANE_W +: LANE_W];
  end

  // array commit and write buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      bufValid <= 1'b0;
      bufAddr  <= '0;
      bufMask  <= '0;
      bufData  <= '0;
    end else if (strb.loadBuf) begin
      if (bufValid) begin
        for (int l = 0; l < LANES; l++) begin
          if (bufMask[l]) mem[bufAddr][l*LANE_W +: LANE_W] <= bufData[l*LANE_W +: LANE_W];
        end
      end
      bufValid <= 1'b1;
      bufAddr  <= cmdAddr;
      bufMask  <= cmdMask;
      bufData  <= dqIn;
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (!rstN) outData <= '0;
    else if (strb.readLd) outData <= rdMerged;
  end
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [LANES-1:0]  laneWe,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqDrive,
  input  logic              outEn
);
  strb_t             strb;
  logic [ADDR_W-1:0] cmdAddr;
  logic [LANES-1:0]  cmdMask;
  logic              driveSlot;
  logic              bufValid;
  logic [ADDR_W-1:0] bufAddr;
  logic [DATA_W-1:0] bufData;

  lwsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addrIn(addrIn),
    .laneWe(laneWe), .strb(strb), .cmdAddr(cmdAddr), .cmdMask(cmdMask),
    .driveSlot(driveSlot)
  );

  lwsram_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdAddr(cmdAddr), .cmdMask(cmdMask),
    .dqIn(dqIn), .outData(dqOut), .bufValid(bufValid), .bufAddr(bufAddr),
    .bufData(bufData)
  );

  assign dqDrive = driveSlot & outEn;
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic              wrEn,
  input logic              outEn,
  input logic              dqDrive,
  input strb_t             strb,
  input logic              bufValid,
  input logic [ADDR_W-1:0] bufAddr,
  input logic [DATA_W-1:0] bufData
);
  // R1
  read_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !wrEn) |=> ##1 (dqDrive == outEn));

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn) |=> ##1 !dqDrive);

  // R7
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> ##1 !dqDrive);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !dqDrive);

  // R3
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufValid && !strb.loadBuf) |=> ($stable(bufAddr) && $stable(bufData) && bufValid));

  // R9
  buf_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufValid) |-> $past(strb.loadBuf));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadBuf, strb.readLd}));
endmodule

bind lwsram_core lwsram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .outEn(outEn),
  .dqDrive(dqDrive), .strb(strb), .bufValid(bufValid), .bufAddr(bufAddr),
  .bufData(bufData)
);

// File: tb/lwsram_core_tb_top.sv
module lwsram_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 1'b0, wrEn = 1'b0, outEn = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [LANES-1:0]  laneWe = '0;
  logic [DATA_W-1:0] dqIn = '0;
  logic [DATA_W-1:0] dqOut;
  logic dqDrive;

  int checks = 0, failures = 0;

  logic [DATA_W-1:0] model [DEPTH];
  logic prevWr = 1'b0;
  logic [ADDR_W-1:0] prevAddr = '0, lastWrAddr = '0;
  logic [LANES-1:0] prevMask = '0;
  logic haveWr = 1'b0;

  logic exp1Drv = 1'b0, exp2Drv = 1'b0, lastDrv = 1'b0;
  logic [DATA_W-1:0] exp1Dat = '0, exp2Dat = '0, lastDat = '0;
  string exp1Tag = "R9", exp2Tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  lwsram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addrIn(addrIn),
    .laneWe(laneWe), .dqIn(dqIn), .dqOut(dqOut), .dqDrive(dqDrive), .outEn(outEn)
  );

  function automatic logic [DATA_W-1:0] applyMask(input logic [DATA_W-1:0] old,
      input logic [DATA_W-1:0] nw, input logic [LANES-1:0] m);
    logic [DATA_W-1:0] r = old;
    for (int l = 0; l < LANES; l++)
      if (m[l]) r[l*LANE_W +: LANE_W] = nw[l*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic checkBus(input logic eDrv, input logic [DATA_W-1:0] eDat, input string tag);
    logic want = eDrv && outEn;
    checks++;
    if (dqDrive !== want || (want && dqOut !== eDat)) begin
      failures++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, dqDrive, dqOut, want, eDat);
    end
  endtask

  // one cycle: check slot of command from two steps ago, then drive
  task automatic step(input logic s, input logic w, input logic [ADDR_W-1:0] a,
      input logic [LANES-1:0] m, input logic [DATA_W-1:0] d, input string tag = "");
    @(negedge clk);
    checkBus(exp2Drv, exp2Dat, exp2Tag);
    lastDrv = exp2Drv; lastDat = exp2Dat;
    exp2Drv = exp1Drv; exp2Dat = exp1Dat; exp2Tag = exp1Tag;
    sel = s; wrEn = w; addrIn = a; laneWe = m; dqIn = d;
    if (prevWr) model[prevAddr] = applyMask(model[prevAddr], d, prevMask);
    exp1Drv = s && !w;
    exp1Dat = exp1Drv ? model[a] : '0;
    if (tag != "") exp1Tag = tag;
    else if (!exp1Drv) exp1Tag = "R7";
    else if (haveWr && a == lastWrAddr) exp1Tag = "R4";
    else exp1Tag = "R1";
    prevWr = s && w; prevAddr = a; prevMask = m;
    if (s && w) begin haveWr = 1'b1; lastWrAddr = a; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dqDrive !== 1'b0) begin failures++; $display("FAIL R9: drive=%0b expected 0", dqDrive); end
    rstN = 1'b1;
    // R9: reads after reset return zero, nothing parked
    step(1, 0, 6'd0, 4'h0, 36'h0, "R9");
    step(1, 0, 6'd9, 4'hF, 36'hF_FFFF_FFFF, "R9");
    // R2: dqIn at command edge ignored, next-edge data kept
    step(1, 1, 6'd2, 4'hF, 36'h1_1111_1111);
    step(1, 0, 6'd2, 4'h0, 36'h0_ABCD_1234, "R2");
    // R3: parked write visible across reads and deselects, then committed
    step(0, 0, 6'd2, 4'h0, 36'h0);
    step(1, 0, 6'd2, 4'h0, 36'h0, "R3");
    step(1, 0, 6'd7, 4'h0, 36'h0);
    step(1, 1, 6'd3, 4'hF, 36'h0);
    step(1, 0, 6'd2, 4'h0, 36'h5_5555_5555, "R3");
    step(1, 0, 6'd3, 4'h0, 36'h0, "R3");
    // R4: full write, partial overwrite parked, read merges
    step(1, 1, 6'd6, 4'hF, 36'h0);
    step(1, 1, 6'd6, 4'b0010, 36'h9_8765_4321);
    step(1, 0, 6'd6, 4'h0, 36'hF_0F0F_0F0F, "R4");
    // R5: lanes 0 and 2 only; then commit and read from array
    step(1, 1, 6'd4, 4'b0101, 36'h0);
    step(1, 1, 6'd5, 4'hF, 36'hE_DCBA_9876);
    step(1, 0, 6'd4, 4'h0, 36'h1_2345_6789, "R5");
    step(1, 0, 6'd6, 4'h0, 36'h0, "R5");
    // R6: empty mask write changes nothing
    step(1, 1, 6'd5, 4'h0, 36'h0);
    step(1, 0, 6'd5, 4'h0, 36'h3_3333_3333, "R6");
    step(1, 1, 6'd8, 4'hF, 36'h0);
    step(1, 0, 6'd5, 4'h0, 36'h2_4680_1357, "R6");
    step(0, 0, 6'd0, 4'h0, 36'h0);
    // R8: asynchronous output enable during a read slot
    step(0, 0, 6'd0, 4'h0, 36'h0);
    #2 outEn = 1'b0;
    #1 checks++;
    if (dqDrive !== 1'b0) begin failures++; $display("FAIL R8: drive=%0b expected 0", dqDrive); end
    outEn = 1'b1;
    #1 checkBus(lastDrv, lastDat, "R8");
    // random phase
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 3000; n++) begin
      logic s = ($urandom % 8) != 0;
      logic w = $urandom % 2;
      logic [ADDR_W-1:0] a = ADDR_W'($urandom % 8);
      logic [LANES-1:0] m = LANES'($urandom);
      logic [DATA_W-1:0] d = {4'($urandom), $urandom};
      step(s, w, a, m, d);
    end
    step(0, 0, 6'd0, 4'h0, 36'h0);
    step(0, 0, 6'd0, 4'h0, 36'h0);
    step(0, 0, 6'd0, 4'h0, 36'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule